// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block sits between an internal requester and an asynchronous external memory bus that has eight chip-select spaces. It accepts one access at a time through a valid/ready handshake. For each accepted access it decides how many quiet cycles must come before it. It then drives a one-hot active-low chip-select and an active-low read or write strobe.

The spaces are paired by their low index bits. Spaces 0 and 4 form pair A, 1 and 5 form pair B, 2 and 6 form pair C, and 3 and 7 form pair D. Two accesses in a row inside pair A or pair B may be separated by one quiet cycle, so the external device sees its chip-select go inactive between them. A write that directly follows a read is separated by a programmable number of quiet cycles. When both rules apply, the larger count wins. Pair D can have its chip-select held for one extra cycle before and one extra cycle after the strobe.

A five-bit configuration register holds all of these settings and can be read back at any time. Every access takes a fixed two cycles: an address cycle with the chip-select low, then a strobe cycle. The two extension cycles of pair D come on top of these.

Top module: `ext_bus_idle_ctl`

## Requirements
- R1: After reset, every `bus_cs_n` bit, `bus_rd_n` and `bus_wr_n` are 1, `req_ready` is 1, and `cfg_rd_data` reads 5'b11111.
- R2: A write through `cfg_wr_en` is read back on `cfg_rd_data` from the next cycle. Field layout: bit 0 is the pair A (spaces 0/4) idle enable, bit 1 is the pair B (spaces 1/5) idle enable, bit 2 is the pair D (spaces 3/7) extension enable, and bits 4:3 are the read-to-write idle count (0 to 3).
- R3: A basic access drives `bus_cs_n[space]` low for two cycles, with only that bit low. The strobe is high in the first cycle. In the second cycle `bus_rd_n` is low for a read (`req_write`=0) or `bus_wr_n` is low for a write. The strobe is never low for more than one cycle.
- R4: When the enable for pair A or pair B is 1, an access accepted during the last cycle of a previous access in the same pair is preceded by exactly one quiet cycle. This holds for either order of the two spaces and for the same space twice.
- R5: When the pair's enable is 0, or the two accesses are in different pairs, or either access is in pair C or pair D, no quiet cycle comes from the pair rule.
- R6: A write accepted right after a read is preceded by max(read-to-write count, quiet cycles from the pair rule) quiet cycles. A write followed by a read, or two accesses in the same direction, adds nothing through this rule.
- R7: For spaces 3 and 7 with the extension enable at 1, the access lasts four cycles: chip-select alone, then the address cycle, then the strobe, then chip-select alone. With the enable at 0, the access lasts two cycles.
- R8: `req_ready` is 0 during quiet cycles and during every access cycle except the last. A request is accepted only when `req_valid` and `req_ready` are both 1.
- R9: An access accepted while the bus is idle (no access was in progress in that cycle) gets no quiet cycles, whatever came before it.
- R10: During quiet cycles, all chip-select and strobe outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| req_valid | input | 1 | Requester has an access to issue |
| req_ready | output | 1 | Block takes the access at this clock edge |
| req_space | input | 3 | Chip-select space of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | 5 | New configuration value |
| cfg_rd_data | output | 5 | Current configuration value |
| bus_cs_n | output | 8 | Active-low chip-selects, one per space |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
A wrong remembered space, direction or "previous access still present" flag shows up at the pins at once. The second access of a pair starts one or more cycles earlier or later than it should, and the cycle-exact trace that the bench compares catches this at the first affected pin sample. A stuck quiet-cycle counter or sequencer state shows up within a few cycles. It either stretches the quiet gap, starts a strobe with no address cycle before it, or raises `req_ready` early. Every one of these changes the recorded trace. Because every pair of spaces and directions is swept under several settings, each rule is tested in every combination of pairs.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  localparam int EBI_RTW_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GAP  = 3'd1,
    ST_PRE  = 3'd2,
    ST_ADDR = 3'd3,
    ST_STRB = 3'd4,
    ST_POST = 3'd5
  } ebi_state_e;

  typedef struct packed {
    logic [EBI_RTW_W-1:0] rtw_idle;
    logic                 cs_ext;
    logic                 idle_b;
    logic                 idle_a;
  } ebi_cfg_t;

  localparam int EBI_CFG_W = $bits(ebi_cfg_t);
endpackage

// File: rtl/ebi_rst_sync.sv
module ebi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ebi_cfg_reg.sv
module ebi_cfg_reg
  import ebi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  ebi_cfg_t wr_data,
  output ebi_cfg_t cfg
);
  ebi_cfg_t cfg_q;
  ebi_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '1;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/ebi_gap_calc.sv
module ebi_gap_calc
  import ebi_pkg::*;
#(
  parameter int NUM_CS  = 8,
  parameter int GRP_A   = 0,
  parameter int GRP_B   = 1,
  parameter int EXT_GRP = 3,
  localparam int SP_W   = $clog2(NUM_CS)
) (
  input  logic                 hist_valid,
  input  logic [SP_W-1:0]      prev_space,
  input  logic                 prev_write,
  input  logic [SP_W-1:0]      req_space,
  input  logic                 req_write,
  input  ebi_cfg_t             cfg,
  output logic [EBI_RTW_W-1:0] gap,
  output logic                 req_ext
);
  localparam logic [SP_W-1:0] GMASK = SP_W'(NUM_CS / 2 - 1);

  logic [SP_W-1:0]      g_prev;
  logic [SP_W-1:0]      g_req;
  logic                 cont_en;
  logic [EBI_RTW_W-1:0] gap_cont;
  logic [EBI_RTW_W-1:0] gap_rtw;

  always_comb begin
    g_prev = prev_space & GMASK;
    g_req  = req_space & GMASK;
    if (g_req == SP_W'(GRP_A))      cont_en = cfg.idle_a;
    else if (g_req == SP_W'(GRP_B)) cont_en = cfg.idle_b;
    else                            cont_en = 1'b0;
    gap_cont = (hist_valid && (g_prev == g_req) && cont_en) ? EBI_RTW_W'(1) : '0;
    gap_rtw  = (hist_valid && !prev_write && req_write) ? cfg.rtw_idle : '0;
    gap      = (gap_rtw > gap_cont) ? gap_rtw : gap_cont;
    req_ext  = cfg.cs_ext && (g_req == SP_W'(EXT_GRP));
  end
endmodule

// File: rtl/ebi_seq.sv
module ebi_seq
  import ebi_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SP_W  = $clog2(NUM_CS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [SP_W-1:0]      req_space,
  input  logic                 req_write,
  input  logic [EBI_RTW_W-1:0] gap_in,
  input  logic                 req_ext,
  output logic                 req_ready,
  output logic                 hist_valid,
  output logic [SP_W-1:0]      cur_space,
  output logic                 cur_write,
  output ebi_state_e           st,
  output logic [NUM_CS-1:0]    cs_n,
  output logic                 rd_n,
  output logic                 wr_n
);
  ebi_state_e           st_q, st_d;
  logic [EBI_RTW_W-1:0] cnt_q, cnt_d;
  logic [SP_W-1:0]      space_q, space_d;
  logic                 write_q, write_d;
  logic                 ext_q, ext_d;
  logic [NUM_CS-1:0]    cs_n_q, cs_n_d;
  logic                 rd_n_q, rd_n_d;
  logic                 wr_n_q, wr_n_d;
  logic                 last_cyc;
  logic                 ready;
  logic                 accept;
  logic                 cnt_en;
  logic                 bus_on;

  always_comb begin
    last_cyc = ((st_q == ST_STRB) && !ext_q) || (st_q == ST_POST);
    ready    = (st_q == ST_IDLE) || last_cyc;
    accept   = req_valid && ready;
    cnt_en   = accept || (st_q == ST_GAP);

    space_d = accept ? req_space : space_q;
    write_d = accept ? req_write : write_q;
    ext_d   = accept ? req_ext   : ext_q;

    st_d  = st_q;
    cnt_d = cnt_q;
    if (ready) begin
      if (accept) begin
        if (gap_in != '0) begin
          st_d  = ST_GAP;
          cnt_d = gap_in - EBI_RTW_W'(1);
        end else begin
          st_d = req_ext ? ST_PRE : ST_ADDR;
        end
      end else begin
        st_d = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_GAP: begin
          if (cnt_q == '0) st_d = ext_q ? ST_PRE : ST_ADDR;
          else             cnt_d = cnt_q - EBI_RTW_W'(1);
        end
        ST_PRE:  st_d = ST_ADDR;
        ST_ADDR: st_d = ST_STRB;
        ST_STRB: st_d = ST_POST;
        default: st_d = ST_IDLE;
      endcase
    end

    bus_on = (st_d == ST_PRE) || (st_d == ST_ADDR) ||
             (st_d == ST_STRB) || (st_d == ST_POST);
    cs_n_d = bus_on ? ~(NUM_CS'(1) << space_d) : '1;
    rd_n_d = !((st_d == ST_STRB) && !write_d);
    wr_n_d = !((st_d == ST_STRB) && write_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_n_q <= '1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= '0;
      write_q <= 1'b0;
      ext_q   <= 1'b0;
    end else if (accept) begin
      space_q <= space_d;
      write_q <= write_d;
      ext_q   <= ext_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign req_ready  = ready;
  assign hist_valid = last_cyc;
  assign cur_space  = space_q;
  assign cur_write  = write_q;
  assign st         = st_q;
  assign cs_n       = cs_n_q;
  assign rd_n       = rd_n_q;
  assign wr_n       = wr_n_q;
endmodule

// File: rtl/ext_bus_idle_ctl.sv
module ext_bus_idle_ctl
  import ebi_pkg::*;
#(
  parameter int NUM_CS  = 8,
  parameter int GRP_A   = 0,
  parameter int GRP_B   = 1,
  parameter int EXT_GRP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(NUM_CS)-1:0]  req_space,
  input  logic                       req_write,
  input  logic                       cfg_wr_en,
  input  logic [EBI_CFG_W-1:0]       cfg_wr_data,
  output logic [EBI_CFG_W-1:0]       cfg_rd_data,
  output logic [NUM_CS-1:0]          bus_cs_n,
  output logic                       bus_rd_n,
  output logic                       bus_wr_n
);
  localparam int SP_W = $clog2(NUM_CS);

  logic                 rst_n_s;
  ebi_cfg_t             cfg;
  logic                 hist_valid;
  logic [SP_W-1:0]      cur_space;
  logic                 cur_write;
  logic [EBI_RTW_W-1:0] gap;
  logic                 req_ext;
  ebi_state_e           st_w;

  ebi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ebi_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_wr_en),
    .wr_data (ebi_cfg_t'(cfg_wr_data)),
    .cfg     (cfg)
  );

  ebi_gap_calc #(
    .NUM_CS  (NUM_CS),
    .GRP_A   (GRP_A),
    .GRP_B   (GRP_B),
    .EXT_GRP (EXT_GRP)
  ) u_gap (
    .hist_valid (hist_valid),
    .prev_space (cur_space),
    .prev_write (cur_write),
    .req_space  (req_space),
    .req_write  (req_write),
    .cfg        (cfg),
    .gap        (gap),
    .req_ext    (req_ext)
  );

  ebi_seq #(.NUM_CS(NUM_CS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_space  (req_space),
    .req_write  (req_write),
    .gap_in     (gap),
    .req_ext    (req_ext),
    .req_ready  (req_ready),
    .hist_valid (hist_valid),
    .cur_space  (cur_space),
    .cur_write  (cur_write),
    .st         (st_w),
    .cs_n       (bus_cs_n),
    .rd_n       (bus_rd_n),
    .wr_n       (bus_wr_n)
  );

  assign cfg_rd_data = cfg;
endmodule

// File: rtl/ext_bus_idle_ctl_chk.sv
module ext_bus_idle_ctl_chk
  import ebi_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NUM_CS-1:0] cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input ebi_state_e        st
);
  // R3: at most one chip-select active
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R3: read and write strobes never together
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3: a strobe only inside an active chip-select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (cs_n != '1));

  // R3: a strobe lasts one cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |=> (rd_n && wr_n));

  // R10: quiet cycles drive nothing
  p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> (cs_n == '1 && rd_n && wr_n));

  // R8: no acceptance during quiet or early access cycles
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP || st == ST_PRE || st == ST_ADDR) |-> !req_ready);

  // R9: access taken from idle never waits
  p_fresh_nogap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && req_ready) |=> (st != ST_GAP));

  // R7: the leading extension cycle keeps the same chip-select into the address cycle
  p_ext_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |=> (st == ST_ADDR && $stable(cs_n)));
endmodule

bind ext_bus_idle_ctl ext_bus_idle_ctl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (bus_cs_n),
  .rd_n      (bus_rd_n),
  .wr_n      (bus_wr_n),
  .st        (st_w)
);

// File: tb/ext_bus_idle_ctl_bench.sv
module ext_bus_idle_ctl_bench;
  localparam int TRACE_N = 14;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [2:0] req_space;
  logic       req_write;
  logic       cfg_wr_en;
  logic [4:0] cfg_wr_data;
  logic [4:0] cfg_rd_data;
  logic [7:0] bus_cs_n;
  logic       bus_rd_n;
  logic       bus_wr_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ext_bus_idle_ctl u_ext_bus_idle_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_space   (req_space),
    .req_write   (req_write),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] pin_word(input int sp, input bit w,
                                          input bit strobe, input bit on);
    if (!on) return 10'h3FF;
    return {~(8'(1) << sp), !(strobe && !w), !(strobe && w)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check(cfg_rd_data == v, "R2", "config readback", 32'(cfg_rd_data), 32'(v));
  endtask

  task automatic run_pair(input int s1, input bit w1, input int s2, input bit w2,
                          input bit spaced, input logic [4:0] cfg, input string tag);
    logic [9:0] got [TRACE_N];
    logic [9:0] exp [TRACE_N];
    int  g1, g2, l1, l2, gap, cont, rg, st2;
    bit  e1, e2;
    logic rdy_after;
    g1 = s1 % 4;
    g2 = s2 % 4;
    e1 = cfg[2] && (g1 == 3);
    e2 = cfg[2] && (g2 == 3);
    l1 = e1 ? 4 : 2;
    l2 = e2 ? 4 : 2;
    cont = ((g1 == g2) && ((g2 == 0 && cfg[0]) || (g2 == 1 && cfg[1]))) ? 1 : 0;
    rg   = (!w1 && w2) ? int'(cfg[4:3]) : 0;
    gap  = spaced ? 1 : ((rg > cont) ? rg : cont);
    st2  = l1 + gap;
    for (int i = 0; i < TRACE_N; i++) begin
      if (i < l1)
        exp[i] = pin_word(s1, w1, i == (e1 ? 2 : 1), 1'b1);
      else if (i >= st2 && i < st2 + l2)
        exp[i] = pin_word(s2, w2, (i - st2) == (e2 ? 2 : 1), 1'b1);
      else
        exp[i] = 10'h3FF;
    end
    rdy_after = 1'b1;
    fork
      begin
        logic rdy;
        req_space = 3'(s1);
        req_write = w1;
        req_valid = 1'b1;
        forever begin
          rdy = req_ready;
          @(negedge clk);
          if (rdy) break;
        end
        rdy_after = req_ready;
        if (spaced) begin
          req_valid = 1'b0;
          repeat (l1) @(negedge clk);
          req_valid = 1'b1;
        end
        req_space = 3'(s2);
        req_write = w2;
        forever begin
          rdy = req_ready;
          @(negedge clk);
          if (rdy) break;
        end
        req_valid = 1'b0;
      end
      begin
        @(negedge clk);
        for (int i = 0; i < TRACE_N; i++) begin
          got[i] = {bus_cs_n, bus_rd_n, bus_wr_n};
          @(negedge clk);
        end
      end
    join
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < TRACE_N; i++)
        if (bad < 0 && got[i] !== exp[i]) bad = i;
      check(bad < 0, tag,
            $sformatf("trace s%0d w%0d -> s%0d w%0d cfg=%b cycle %0d",
                      s1, w1, s2, w2, cfg, (bad < 0) ? 0 : bad),
            32'((bad < 0) ? got[0] : got[bad]), 32'((bad < 0) ? exp[0] : exp[bad]));
    end
    if (spaced)
      check(rdy_after == 1'b0, "R8", "ready during first access cycle",
            32'(rdy_after), 32'(0));
  endtask

  initial begin
    done = 0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] cfg_list [5];
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_space   = '0;
    req_write   = 1'b0;
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
    cfg_list[0] = 5'b11111;
    cfg_list[1] = 5'b00000;
    cfg_list[2] = 5'b01001;
    cfg_list[3] = 5'b10010;
    cfg_list[4] = 5'b00111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(bus_cs_n == 8'hFF, "R1", "cs after reset", 32'(bus_cs_n), 32'hFF);
    check(bus_rd_n && bus_wr_n, "R1", "strobes after reset",
          32'({bus_rd_n, bus_wr_n}), 32'h3);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    check(cfg_rd_data == 5'h1F, "R1", "config after reset", 32'(cfg_rd_data), 32'h1F);

    // R9 with reset config: history is cleared by an idle cycle
    run_pair(1, 0, 5, 1, 1'b1, 5'h1F, "R9");
    run_pair(0, 1, 0, 1, 1'b1, 5'h1F, "R9");
    run_pair(3, 0, 7, 1, 1'b1, 5'h1F, "R9 R7");

    // Sweep: R3 R4 R5 R6 R7 R10 across all space/direction pairs
    for (int c = 0; c < 5; c++) begin
      cfg_write(cfg_list[c]);
      for (int s1 = 0; s1 < 8; s1++)
        for (int s2 = 0; s2 < 8; s2++)
          for (int w1 = 0; w1 < 2; w1++)
            for (int w2 = 0; w2 < 2; w2++)
              run_pair(s1, w1[0], s2, w2[0], 1'b0, cfg_list[c],
                       "R3 R4 R5 R6 R7 R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule